// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host side of a 4-wire link to a 12-bit, 8-channel successive-approximation converter. A single-cycle start request carries a channel number, input-type flags, a power field and a clock-mode select. The block pulls chip select low and shifts an 8-bit control byte out on the serial data line, MSB first. It then collects the 12-bit result from the converter's serial output. At the end it raises chip select and pulses done for one cycle, with the result held on a registered output.

The serial clock comes from the system clock through a programmable divider and has a 50% duty cycle. The block has two conversion modes. In the external-clock mode the serial clock keeps running after the control byte. The converter's strobe pulses high for one serial-clock period, and the 12 result bits are taken on the rising edges that follow that pulse. In the internal-clock mode the serial clock stops after the control byte. The block waits for the strobe to go low and then high again, and only then clocks in the result.

Top module: `sar_adc_host`

## Requirements
- R1: While reset is high, and on the first cycle after it, cs_n_o is 1, sclk_o is 0, din_o is 0, busy_o is 0 and done_o is 0.
- R2: The control byte is sent MSB first. Its bits are, from bit 7 down:
  - bit 7 is a constant 1;
  - bits 6:4 are the channel select;
  - bit 3 is 1 for unipolar and 0 for bipolar (bipolar_i=1 gives 0);
  - bit 2 is 1 for single-ended and 0 for differential (diff_i=1 gives 0);
  - bits 1:0 are pwr_i.
- R3: In differential mode, bit 4 of the control byte is forced to 0, so the channel field names the even channel of pair chan_i[2:1]. In single-ended mode, bits 6:4 equal chan_i.
- R4: din_o changes only while sclk_o is low, so each bit is stable at the rising SCLK edge where the converter samples it.
- R5: Every SCLK high phase lasts exactly DIV_HALF system cycles. Every low phase between two SCLK pulses inside a continuous run also lasts DIV_HALF cycles (default 2, i.e. SCLK = clk/4).
- R6: In external-clock mode, SCLK runs without a gap after the 8th control bit. When the strobe is seen high at a rising SCLK edge, the next 12 rising edges capture dout_i as result bits 11 down to 0.
- R7: In internal-clock mode, SCLK stays low after the 8th control bit until the strobe has been seen low and then high. After that, 12 SCLK pulses capture dout_i, MSB first, on their rising edges.
- R8: cs_n_o is low for the whole of a transaction and high otherwise. SCLK never pulses while cs_n_o is high.
- R9: A start request while busy_o is high is ignored. It does not change the control byte or the result, and it does not start a second transaction.
- R10: done_o is high for exactly one cycle per transaction, with result_o valid in that cycle. result_o then holds its value until the next done.
- R11: dout_i has no effect on result_o while cs_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled only when idle |
| chan_i | input | 3 | Channel number |
| diff_i | input | 1 | 1 = differential pair input |
| bipolar_i | input | 1 | 1 = bipolar coding |
| pwr_i | input | 2 | Power field copied into the control byte |
| intclk_i | input | 1 | 1 = internal-clock conversion, 0 = SCLK-driven conversion |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when result_o is valid |
| result_o | output | 12 | Last conversion result |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| din_o | output | 1 | Serial data to the converter |
| dout_i | input | 1 | Serial data from the converter |
| strobe_i | input | 1 | Converter strobe |

## Verification
The hardest case to reach is the alignment between the strobe and the result capture. A capture that is off by one SCLK edge still yields a 12-bit value and a done pulse, so a weak check would not see it. The bench therefore models the converter directly. It decodes the control byte on the rising SCLK edges and raises the strobe at the exact point the mode prescribes: on the 8th falling edge in external mode, or after a delay with SCLK held idle in internal mode. It puts the MSB out at the edge where the real part would. The result patterns include asymmetric words, all-ones and a lone LSB, so a one-bit shift in either direction changes the value the bench compares.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CMD, ST_EXT_WAIT, ST_INT_LOW, ST_INT_HIGH, ST_RX, ST_TAIL
  } sadc_state_e;

  // Control byte: start, channel[2:0], unipolar, single-ended, power[1:0]
  function automatic logic [7:0] sadc_ctrl_byte(input logic [2:0] chan,
                                                input logic bipolar,
                                                input logic diff,
                                                input logic [1:0] pwr);
    logic [2:0] sel;
    sel = diff ? {chan[2:1], 1'b0} : chan;
    return {1'b1, sel, ~bipolar, ~diff, pwr};
  endfunction
endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap   = en && (cnt == CW'(DIV_HALF - 1));
  assign rise_o = wrap && !sclk_o;
  assign fall_o = wrap && sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_tx_shift.sv
module sadc_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] data_i,
  output logic         bit_o
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= data_i;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign bit_o = sr[W-1];
endmodule

// File: rtl/sadc_rx_shift.sv
module sadc_rx_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)        word_o <= '0;
    else if (shift) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
  import sadc_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int RES_W    = 12,
  parameter int CMD_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       chan_i,
  input  logic             diff_i,
  input  logic             bipolar_i,
  input  logic [1:0]       pwr_i,
  input  logic             intclk_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             din_o,
  input  logic             dout_i,
  input  logic             strobe_i
);
  localparam int MAXB = (RES_W > CMD_W) ? RES_W : CMD_W;
  localparam int BCW  = $clog2(MAXB + 1);

  sadc_state_e      state;
  logic [BCW-1:0]   bit_cnt;
  logic             int_mode;
  logic             sclk_en, rise, fall;
  logic             tx_load, tx_shift, rx_shift;
  logic [RES_W-1:0] rx_word;

  assign sclk_en  = (state == ST_CMD) || (state == ST_EXT_WAIT) ||
                    (state == ST_RX)  || (state == ST_TAIL);
  assign tx_load  = (state == ST_IDLE) && start_i;
  assign tx_shift = (state == ST_CMD) && fall;
  assign rx_shift = (state == ST_RX) && rise;
  assign busy_o   = (state != ST_IDLE);

  sadc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk(clk), .rst(rst), .en(sclk_en),
    .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
  );

  sadc_tx_shift #(.W(CMD_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .shift(tx_shift),
    .data_i(CMD_W'(sadc_ctrl_byte(chan_i, bipolar_i, diff_i, pwr_i))),
    .bit_o(din_o)
  );

  sadc_rx_shift #(.W(RES_W)) u_rx (
    .clk(clk), .rst(rst), .shift(rx_shift), .bit_i(dout_i), .word_o(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n_o   <= 1'b1;
      bit_cnt  <= '0;
      int_mode <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          state    <= ST_SETUP;
          cs_n_o   <= 1'b0;
          bit_cnt  <= '0;
          int_mode <= intclk_i;
        end
        ST_SETUP: state <= ST_CMD;
        ST_CMD: if (fall) begin
          if (bit_cnt == BCW'(CMD_W - 1)) begin
            bit_cnt <= '0;
            state   <= int_mode ? ST_INT_LOW : ST_EXT_WAIT;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_EXT_WAIT: if (rise && strobe_i) state <= ST_RX;
        ST_INT_LOW:  if (!strobe_i) state <= ST_INT_HIGH;
        ST_INT_HIGH: if (strobe_i)  state <= ST_RX;
        ST_RX: if (rise) begin
          if (bit_cnt == BCW'(RES_W - 1)) begin
            bit_cnt <= '0;
            state   <= ST_TAIL;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_TAIL: if (fall) begin
          result_o <= rx_word;
          done_o   <= 1'b1;
          cs_n_o   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_host_chk.sv
module sar_adc_host_chk #(
  parameter int DIV_HALF = 2,
  parameter int RES_W    = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             din_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);
  logic [15:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst)         hi_len <= '0;
    else if (sclk_o) hi_len <= hi_len + 1'b1;
    else             hi_len <= '0;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cs_n_o && !sclk_o && !din_o && !busy_o && !done_o));

  assert_din_setup_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(din_o) |-> !sclk_o);

  assert_sclk_high_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> (hi_len == 16'(DIV_HALF)));

  assert_no_sclk_idle_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  assert_busy_cs_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !cs_n_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));
endmodule

bind sar_adc_host sar_adc_host_chk #(.DIV_HALF(DIV_HALF), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .din_o(din_o),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/sar_adc_host_tb_top.sv
module sar_adc_host_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, diff_i = 1'b0, bipolar_i = 1'b0, intclk_i = 1'b0;
  logic [2:0] chan_i = '0;
  logic [1:0] pwr_i = '0;
  logic dout_i = 1'b0, strobe_i = 1'b0;
  logic busy_o, done_o, cs_n_o, sclk_o, din_o;
  logic [11:0] result_o;

  always #2.5 clk = ~clk;

  sar_adc_host dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .diff_i(diff_i),
    .bipolar_i(bipolar_i), .pwr_i(pwr_i), .intclk_i(intclk_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .din_o(din_o), .dout_i(dout_i), .strobe_i(strobe_i)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {intclk, diff, bipolar, chan[2:0], pwr[1:0], sample[11:0]}
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 3'd5, 2'b11, 12'hA5C},
    {1'b0, 1'b1, 1'b1, 3'd3, 2'b01, 12'h800},
    {1'b1, 1'b0, 1'b0, 3'd0, 2'b01, 12'hFFF},
    {1'b1, 1'b1, 1'b0, 3'd7, 2'b10, 12'h001},
    {1'b0, 1'b0, 1'b1, 3'd7, 2'b00, 12'h000},
    {1'b1, 1'b0, 1'b1, 3'd2, 2'b11, 12'h5A3}
  };

  function automatic logic [7:0] exp_byte(input logic [2:0] c, input logic b,
                                          input logic d, input logic [1:0] p);
    logic [2:0] f;
    f = d ? {c[2:1], 1'b0} : c;
    return {1'b1, f, !b, !d, p};
  endfunction

  // converter model
  logic        m_int = 1'b0;
  logic [11:0] m_sample = '0;
  logic [7:0]  m_byte = '0;
  int          rises = 0, cs_falls = 0;
  always @(posedge sclk_o) rises++;
  always @(negedge cs_n_o) cs_falls++;

  initial begin
    forever begin
      @(negedge cs_n_o);
      for (int i = 0; i < 8; i++) begin
        @(posedge sclk_o);
        m_byte = {m_byte[6:0], din_o};
      end
      if (m_int) begin
        int c0;
        @(negedge sclk_o);
        c0 = rises;
        repeat (4) @(negedge clk);
        strobe_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(rises == c0, "R7 sclk idle during internal conversion", rises, c0);
        dout_i = m_sample[11];
        strobe_i = 1'b1;
      end else begin
        @(negedge sclk_o);
        strobe_i = 1'b1;
        @(negedge sclk_o);
        strobe_i = 1'b0;
        dout_i = m_sample[11];
      end
      for (int k = 10; k >= 0; k--) begin
        @(negedge sclk_o);
        dout_i = m_sample[k];
      end
      @(posedge cs_n_o);
      strobe_i = 1'b0;
      dout_i = 1'b1;
    end
  end

  // SCLK phase and DIN monitor
  int  hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0, run = 0, din_bad = 0;
  logic prev_s = 1'b0, prev_din = 1'b0, low_valid = 1'b0;
  always @(negedge clk) begin
    if (sclk_o && prev_s && din_o != prev_din) din_bad++;
    if (sclk_o == prev_s) run++;
    else begin
      if (prev_s) begin
        if (run < hi_min) hi_min = run;
        if (run > hi_max) hi_max = run;
      end else if (low_valid && !m_int) begin
        if (run < lo_min) lo_min = run;
        if (run > lo_max) lo_max = run;
      end
      low_valid = prev_s;
      run = 1;
    end
    if (cs_n_o) low_valid = 1'b0;
    prev_s = sclk_o;
    prev_din = din_o;
  end

  int ndone;
  task automatic issue(input logic it, input logic d, input logic b,
                       input logic [2:0] c, input logic [1:0] p);
    @(negedge clk);
    intclk_i = it; diff_i = d; bipolar_i = b; chan_i = c; pwr_i = p; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    ndone = 0;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (done_o) ndone++;
      if (!busy_o && ndone > 0) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n_o && !sclk_o && !din_o && !busy_o && !done_o, "R1 outputs in reset",
        {cs_n_o, sclk_o, din_o, busy_o, done_o}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n_o && !sclk_o && !busy_o && !done_o, "R1 after reset",
        {cs_n_o, sclk_o, busy_o, done_o}, 4'b1000);

    foreach (VEC[i]) begin
      logic [19:0] v;
      v = VEC[i];
      m_int = v[19];
      m_sample = v[11:0];
      issue(v[19], v[18], v[17], v[16:14], v[13:12]);
      wait_done();
      // R2 field order, R3 differential pairing
      chk(m_byte == exp_byte(v[16:14], v[17], v[18], v[13:12]), "R2/R3 control byte",
          m_byte, exp_byte(v[16:14], v[17], v[18], v[13:12]));
      chk(result_o == v[11:0], v[19] ? "R7 internal-clock result" : "R6 external-clock result",
          result_o, v[11:0]);
      chk(ndone == 1, "R10 single done pulse", ndone, 1);
      repeat (5) @(negedge clk);
    end

    // R5 SCLK phases
    chk(hi_min == 2 && hi_max == 2, "R5 high phase", hi_max, 2);
    chk(lo_min == 2 && lo_max == 2, "R5 low phase", lo_max, 2);
    // R4 DIN stable while SCLK high
    chk(din_bad == 0, "R4 din change while sclk high", din_bad, 0);

    // R9 start while busy is ignored
    begin
      int f0;
      f0 = cs_falls;
      m_int = 1'b0;
      m_sample = 12'h3C7;
      issue(1'b0, 1'b0, 1'b0, 3'd6, 2'b11);
      repeat (30) @(negedge clk);
      issue(1'b1, 1'b1, 1'b1, 3'd1, 2'b00);
      wait_done();
      chk(m_byte == exp_byte(3'd6, 1'b0, 1'b0, 2'b11), "R9 byte kept", m_byte,
          exp_byte(3'd6, 1'b0, 1'b0, 2'b11));
      chk(result_o == 12'h3C7, "R9 result kept", result_o, 12'h3C7);
      repeat (60) @(negedge clk);
      chk(cs_falls == f0 + 1, "R9 no second transaction", cs_falls, f0 + 1);
      // R8 chip select idle
      chk(cs_n_o && !busy_o, "R8 idle after transaction", {cs_n_o, busy_o}, 2'b10);
    end

    // R11 DOUT ignored while chip select high
    begin
      int d0;
      d0 = 0;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        dout_i = t[0] ^ t[2];
        strobe_i = t[1];
        if (done_o) d0++;
      end
      chk(result_o == 12'h3C7, "R11 result unchanged by idle dout", result_o, 12'h3C7);
      chk(d0 == 0, "R11 no done while idle", d0, 0);
      chk(!sclk_o && cs_n_o, "R8 no sclk while idle", sclk_o, 0);
      strobe_i = 1'b0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule